// File: doc/BRIEF.md
# Status/Cause Software-Interrupt Controller

This block keeps the two control registers that a small in-order processor needs for software interrupts: a mode/enable word (Status, index 12) and an interrupt-reason word (Cause, index 13). The core reaches them with move-to and move-from accesses by register index. Every other index up to the register count is plain storage that keeps whatever was last written to it.

The low six bits of Status form a three-level stack of (kernel-mode, interrupt-enable) pairs. Bit 0 is the current interrupt enable. When the core enters an exception, the block pushes this stack and records the exception code in Cause. A return-from-exception command pops the stack. After each write to Status or Cause, the block checks whether a pending software interrupt that is unmasked and enabled is present. If one is, it clears the code field of Cause and raises a one-cycle exception request.

Top module: `cp0_swint_ctrl`

## Requirements
- R1: A return-from-exception command copies Status[5:2] into Status[3:0] and leaves Status[31:4] unchanged.
- R2: A write to Cause (index 13) changes only Cause[9:8], the software-interrupt pending bits. All other Cause bits keep their values.
- R3: A write to Status (index 12) replaces all 32 bits with the written value.
- R4: When a write to Status or Cause leaves (Cause & Status & 0x300) nonzero with Status[0] = 1, `excReq` is high for exactly the cycle after the write's clock edge.
- R5: `excReq` stays low after any cycle that has no write to Status or Cause. This covers return-from-exception, exception entry and writes to other indices, even when the interrupt condition already holds.
- R6: When a software interrupt is taken, Cause[6:2] (exception code) is cleared to zero at the same clock edge, while the Cause[9:8] bits just written are kept.
- R7: A write to any index other than 12 and 13 stores the value unmodified, and that index reads it back.
- R8: Exception entry (`excTake`) shifts Status[5:0] left by two with bits 1:0 cleared, and writes `excTakeCode` into Cause[6:2].
- R9: In a cycle that carries both a Status write and a return or entry command, the written value wins for Status. An entry in that cycle still writes its code into Cause.
- R10: After reset, every register reads zero and `excReq` is low.
- R11: `excCode` always shows Cause[6:2], so it reads 0 while `excReq` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Move-to strobe |
| wrIdx | input | 5 | Register index written |
| wrData | input | 32 | Value written |
| rdIdx | input | 5 | Register index read |
| rdData | output | 32 | Combinational read of register `rdIdx` |
| rfeCmd | input | 1 | Return-from-exception: pop the mode/enable stack |
| excTake | input | 1 | Exception entry: push the stack and record the code |
| excTakeCode | input | 5 | Exception code recorded on entry |
| excReq | output | 1 | One-cycle software-interrupt exception request |
| excCode | output | 5 | Current exception code field of Cause |

## Verification
The bench builds the block with its default parameters: 32 registers, Status at 12, Cause at 13, two software-interrupt bits at 8 and a three-level stack.

These defaults give direct reach to the following cases:
- the enable gate at bit 0 and the mask overlap at bits 9:8;
- a pop that exposes a set enable without raising a request;
- stale exception codes that an interrupt clears;
- same-cycle collisions between a Status write and stack commands.

A plain-storage index is written and read back through the same port map, and the read-back uses the actual plain-storage index numbering.

// File: rtl/cp0_pkg.sv
package cp0_pkg;
  typedef struct packed {
    logic wrStatus;
    logic wrCause;
    logic wrOther;
    logic popStack;
    logic pushStack;
    logic takeSw;
  } cp0Strobe_t;
endpackage

// File: rtl/cp0_ctrl.sv
module cp0_ctrl
  import cp0_pkg::*;
#(
  parameter int IDX_W      = 5,
  parameter int STATUS_IDX = 12,
  parameter int CAUSE_IDX  = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             rfeCmd,
  input  logic             excTake,
  input  logic             swHitNext,
  output cp0Strobe_t       stb,
  output logic             excReq
);
  logic hitStatus, hitCause;

  assign hitStatus = wrEn && (wrIdx == IDX_W'(STATUS_IDX));
  assign hitCause  = wrEn && (wrIdx == IDX_W'(CAUSE_IDX));

  always_comb begin
    stb.wrStatus  = hitStatus;
    stb.wrCause   = hitCause;
    stb.wrOther   = wrEn && !hitStatus && !hitCause;
    stb.pushStack = excTake;
    stb.popStack  = rfeCmd && !excTake;
    stb.takeSw    = (hitStatus || hitCause) && swHitNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) excReq <= 1'b0;
    else       excReq <= stb.takeSw;
  end

  // R5
  no_req_without_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(hitStatus || hitCause) |=> !excReq);
endmodule

// File: rtl/cp0_datapath.sv
module cp0_datapath
  import cp0_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NUM_REGS   = 32,
  parameter int IDX_W      = 5,
  parameter int STATUS_IDX = 12,
  parameter int CAUSE_IDX  = 13,
  parameter int SW_LSB     = 8,
  parameter int SW_BITS    = 2,
  parameter int STACK_LVL  = 3,
  parameter int CODE_LSB   = 2,
  parameter int CODE_W     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  cp0Strobe_t        stb,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CODE_W-1:0] excTakeCode,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData,
  output logic              swHitNext,
  output logic [CODE_W-1:0] excCode
);
  localparam int STK_W = 2 * STACK_LVL;

  logic [DATA_W-1:0] statusQ, causeQ, statusD, causeNext, causeD;
  logic [DATA_W-1:0] plainQ [NUM_REGS];

  always_comb begin
    statusD = statusQ;
    if (stb.wrStatus) begin
      statusD = wrData;
    end else if (stb.pushStack) begin
      statusD[STK_W-1:0] = {statusQ[STK_W-3:0], 2'b00};
    end else if (stb.popStack) begin
      statusD[STK_W-3:0] = statusQ[STK_W-1:2];
    end
  end

  always_comb begin
    causeNext = causeQ;
    if (stb.wrCause)
      causeNext[SW_LSB +: SW_BITS] = wrData[SW_LSB +: SW_BITS];
    if (stb.pushStack)
      causeNext[CODE_LSB +: CODE_W] = excTakeCode;
  end

  assign swHitNext = (|(causeNext[SW_LSB +: SW_BITS] & statusD[SW_LSB +: SW_BITS]))
                     && statusD[0];

  always_comb begin
    causeD = causeNext;
    if (stb.takeSw) causeD[CODE_LSB +: CODE_W] = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      causeQ  <= '0;
    end else begin
      statusQ <= statusD;
      causeQ  <= causeD;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) plainQ[i] <= '0;
    end else if (stb.wrOther) begin
      plainQ[wrIdx] <= wrData;
    end
  end

  always_comb begin
    if (rdIdx == IDX_W'(STATUS_IDX))     rdData = statusQ;
    else if (rdIdx == IDX_W'(CAUSE_IDX)) rdData = causeQ;
    else                                 rdData = plainQ[rdIdx];
  end

  assign excCode = causeQ[CODE_LSB +: CODE_W];

  // R1
  pop_stack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.popStack && !stb.wrStatus) |=>
      (statusQ[STK_W-3:0] == $past(statusQ[STK_W-1:2])) &&
      (statusQ[DATA_W-1:STK_W-2] == $past(statusQ[DATA_W-1:STK_W-2])));

  // R2
  cause_sw_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrCause && !stb.pushStack && !stb.takeSw) |=>
      (causeQ[SW_LSB +: SW_BITS] == $past(wrData[SW_LSB +: SW_BITS])) &&
      (causeQ[SW_LSB-1:0] == $past(causeQ[SW_LSB-1:0])) &&
      (causeQ[DATA_W-1:SW_LSB+SW_BITS] == $past(causeQ[DATA_W-1:SW_LSB+SW_BITS])));

  // R3
  status_full_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrStatus |=> statusQ == $past(wrData));

  // R6
  code_cleared_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.takeSw |=> (causeQ[CODE_LSB +: CODE_W] == '0) && statusQ[0]);

  // R8
  push_stack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pushStack && !stb.wrStatus && !stb.takeSw) |=>
      (statusQ[STK_W-1:0] == {$past(statusQ[STK_W-3:0]), 2'b00}) &&
      (causeQ[CODE_LSB +: CODE_W] == $past(excTakeCode)));
endmodule

// File: rtl/cp0_swint_ctrl.sv
module cp0_swint_ctrl
  import cp0_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NUM_REGS   = 32,
  parameter int STATUS_IDX = 12,
  parameter int CAUSE_IDX  = 13,
  parameter int SW_LSB     = 8,
  parameter int SW_BITS    = 2,
  parameter int STACK_LVL  = 3,
  parameter int CODE_LSB   = 2,
  parameter int CODE_W     = 5,
  localparam int IDX_W     = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData,
  input  logic              rfeCmd,
  input  logic              excTake,
  input  logic [CODE_W-1:0] excTakeCode,
  output logic              excReq,
  output logic [CODE_W-1:0] excCode
);
  cp0Strobe_t stb;
  logic       swHitNext;

  cp0_ctrl #(
    .IDX_W(IDX_W), .STATUS_IDX(STATUS_IDX), .CAUSE_IDX(CAUSE_IDX)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .rfeCmd(rfeCmd),
    .excTake(excTake), .swHitNext(swHitNext), .stb(stb), .excReq(excReq)
  );

  cp0_datapath #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W),
    .STATUS_IDX(STATUS_IDX), .CAUSE_IDX(CAUSE_IDX), .SW_LSB(SW_LSB),
    .SW_BITS(SW_BITS), .STACK_LVL(STACK_LVL), .CODE_LSB(CODE_LSB), .CODE_W(CODE_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrIdx(wrIdx), .wrData(wrData),
    .excTakeCode(excTakeCode), .rdIdx(rdIdx), .rdData(rdData),
    .swHitNext(swHitNext), .excCode(excCode)
  );

  // R11
  req_code_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    excReq |-> excCode == '0);

  // R7
  plain_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrIdx != IDX_W'(STATUS_IDX) && wrIdx != IDX_W'(CAUSE_IDX) && rdIdx == wrIdx)
      |=> (rdIdx != $past(rdIdx)) || (rdData == $past(wrData)));
endmodule

// File: tb/tb_cp0_swint_ctrl.sv
module tb_cp0_swint_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  wrIdx = '0;
  logic [31:0] wrData = '0;
  logic [4:0]  rdIdx = '0;
  logic [31:0] rdData;
  logic        rfeCmd = 1'b0;
  logic        excTake = 1'b0;
  logic [4:0]  excTakeCode = '0;
  logic        excReq;
  logic [4:0]  excCode;

  int compared = 0;
  int mismatched = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  cp0_swint_ctrl dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .rdIdx(rdIdx), .rdData(rdData), .rfeCmd(rfeCmd), .excTake(excTake),
    .excTakeCode(excTakeCode), .excReq(excReq), .excCode(excCode)
  );

  // kind: 0 write, 1 return-from-exception, 2 entry (code = data[4:0]), 3 idle
  typedef struct packed {
    logic [1:0]  kind;
    logic [4:0]  idx;
    logic [31:0] data;
    logic [4:0]  chk;
    logic [31:0] expVal;
    logic [4:0]  expCode;
    logic        expReq;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 5'd12, 32'h0000_0000, 5'd12, 32'h0000_0000, 5'd0, 1'b0},
    '{2'd0, 5'd13, 32'hFFFF_FFFF, 5'd13, 32'h0000_0300, 5'd0, 1'b0},
    '{2'd0, 5'd12, 32'h0000_0301, 5'd12, 32'h0000_0301, 5'd0, 1'b1},
    '{2'd0, 5'd13, 32'h0000_0000, 5'd13, 32'h0000_0000, 5'd0, 1'b0},
    '{2'd2, 5'd0,  32'h0000_0008, 5'd12, 32'h0000_0304, 5'd8, 1'b0},
    '{2'd0, 5'd5,  32'hDEAD_BEEF, 5'd13, 32'h0000_0020, 5'd8, 1'b0},
    '{2'd0, 5'd13, 32'h0000_0100, 5'd13, 32'h0000_0120, 5'd8, 1'b0},
    '{2'd1, 5'd0,  32'h0000_0000, 5'd12, 32'h0000_0301, 5'd8, 1'b0},
    '{2'd0, 5'd13, 32'h0000_0100, 5'd13, 32'h0000_0100, 5'd0, 1'b1},
    '{2'd3, 5'd0,  32'h0000_0000, 5'd5,  32'hDEAD_BEEF, 5'd0, 1'b0},
    '{2'd0, 5'd12, 32'hA5A5_A5A4, 5'd12, 32'hA5A5_A5A4, 5'd0, 1'b0},
    '{2'd1, 5'd0,  32'h0000_0000, 5'd12, 32'hA5A5_A5A9, 5'd0, 1'b0},
    '{2'd0, 5'd13, 32'h0000_0000, 5'd13, 32'h0000_0000, 5'd0, 1'b0},
    '{2'd0, 5'd0,  32'h1234_5678, 5'd0,  32'h1234_5678, 5'd0, 1'b0}
  };

  string tags [NV] = '{"R3", "R2", "R4", "R2", "R8", "R7", "R5", "R1",
                       "R6", "R7", "R3", "R5", "R2", "R7"};

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", tag, what, act, exp);
    end
  endtask

  task automatic readChk(input string tag, input logic [4:0] idx, input logic [31:0] exp);
    rdIdx = idx;
    #1;
    check(tag, "rdData", rdData, exp);
  endtask

  task automatic clearIns();
    wrEn = 1'b0; rfeCmd = 1'b0; excTake = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    readChk("R10", 5'd12, 32'h0);
    readChk("R10", 5'd13, 32'h0);
    check("R10", "excReq", {31'b0, excReq}, 32'h0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      case (VEC[i].kind)
        2'd0: begin wrEn = 1'b1; wrIdx = VEC[i].idx; wrData = VEC[i].data; end
        2'd1: rfeCmd = 1'b1;
        2'd2: begin excTake = 1'b1; excTakeCode = VEC[i].data[4:0]; end
        default: ;
      endcase
      @(negedge clk);
      clearIns();
      readChk(tags[i], VEC[i].chk, VEC[i].expVal);
      check(tags[i], "excReq", {31'b0, excReq}, {31'b0, VEC[i].expReq});
      // R11: code output mirrors Cause[6:2]
      check("R11", "excCode", {27'b0, excCode}, {27'b0, VEC[i].expCode});
    end

    // R9: Status write beats pop and push in the same cycle; entry code still lands
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 5'd12; wrData = 32'h0000_003C;
    rfeCmd = 1'b1; excTake = 1'b1; excTakeCode = 5'd4;
    @(negedge clk);
    clearIns();
    readChk("R9", 5'd12, 32'h0000_003C);
    check("R9", "excCode", {27'b0, excCode}, 32'd4);
    check("R9", "excReq", {31'b0, excReq}, 32'h0);

    // R4: request lasts exactly one cycle
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 5'd13; wrData = 32'h0000_0200;
    @(negedge clk);
    clearIns();
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 5'd12; wrData = 32'h0000_0201;
    @(negedge clk);
    clearIns();
    check("R4", "excReq", {31'b0, excReq}, 32'h1);
    @(negedge clk);
    check("R4", "excReq-drop", {31'b0, excReq}, 32'h0);

    // R10: reset clears everything again
    rstN = 1'b0;
    @(negedge clk);
    readChk("R10", 5'd12, 32'h0);
    readChk("R10", 5'd13, 32'h0);
    readChk("R10", 5'd5, 32'h0);
    check("R10", "excReq", {31'b0, excReq}, 32'h0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule